// File: doc/BRIEF.md
# Protected System Clock Source Switch

This block chooses which of four oscillator sources drives the system clock: the external crystal, the PLL, the low-speed RC oscillator or the high-speed RC oscillator. Software names the wanted source with a 3-bit code. Each source reports a stable flag. The block produces a registered one-hot control for a downstream glitch-free clock multiplexer. The multiplexer and the oscillators are outside this block.

Software may write the select field only after it has unlocked the block. Unlocking takes three bytes written to a protection port in a fixed order. A request for a source that is not yet stable is not refused. The block raises a fail flag and keeps the current source running. When the requested source reports stable, the block switches to it and clears the flag. The reset source comes from a configuration input. A readback output shows whether select writes are currently unlocked.

Top module: `sysclk_src_switch`

## Requirements
- R1: The source codes are 3'b000 for the crystal (one-hot bit 0), 3'b010 for the PLL (bit 1), 3'b011 for the low-speed RC (bit 2) and 3'b111 for the high-speed RC (bit 3). The one-hot output always has exactly one bit set, and that bit matches the active code.
- R2: After reset, the select field and the active code are 3'b111 when `boot_hirc` is 1 and 3'b000 when it is 0. The fail flag is 0 and the block is locked.
- R3: An unlocked select write of a legal code whose target is stable takes effect at the next clock edge. The active code becomes that code and the fail flag becomes 0.
- R4: An unlocked select write of a legal code whose target is not stable stores the code in the select field and sets the fail flag to 1. The active code keeps its old value for as long as the target stays unstable.
- R5: While the fail flag is 1, the first clock edge at which the requested target is stable switches the active code to the requested code and clears the fail flag.
- R6: Writing 8'h59, then 8'h16, then 8'h88 as consecutive protection writes sets `unlocked` to 1 after the third write. A partial sequence leaves the block locked.
- R7: A protection write that does not carry the next expected byte locks the block and restarts the sequence. If that byte is 8'h59, it counts as the first byte of a new sequence. Any protection write made while unlocked locks the block. Select writes do not change the lock state.
- R8: A select write made while the block is locked has no effect on the select field, the active code or the fail flag.
- R9: A select write of a reserved code (3'b001, 3'b100, 3'b101 or 3'b110) leaves the select field and the fail flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_hirc | input | 1 | Reset source choice: 1 selects the high-speed RC, 0 selects the crystal |
| key_wr | input | 1 | Write strobe for the protection port |
| key_data | input | 8 | Byte written to the protection port |
| sel_wr | input | 1 | Write strobe for the select field |
| sel_data | input | 3 | Requested source code |
| src_stable | input | 4 | Stable flags, indexed by one-hot bit position |
| src_onehot | output | 4 | One-hot control for the clock multiplexer |
| active_code | output | 3 | Code of the source now in use |
| sel_field | output | 3 | Select field readback (last accepted request) |
| switch_fail | output | 1 | Requested source was unstable and the switch is pending |
| unlocked | output | 1 | Select writes are currently allowed |

## Verification
The hardest state to reach is a pending switch that meets a later event. The deferral has to last several cycles, and then either the target turns stable or a second request or a reserved code arrives. The stimulus table first opens the lock. It then holds one stable flag low while a request is made. It then sends a reserved code and a superseding legal request in that pending state. Directed steps raise a held-low flag only after a wait. This shows that the switch does not happen before that edge and does happen exactly one edge after it.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
  localparam int SRC_N  = 4;
  localparam int CODE_W = 3;

  typedef logic [CODE_W-1:0] src_code_t;
  typedef logic [SRC_N-1:0]  src_vec_t;

  localparam src_code_t CODE_XTAL = 3'b000;
  localparam src_code_t CODE_PLL  = 3'b010;
  localparam src_code_t CODE_LRC  = 3'b011;
  localparam src_code_t CODE_HRC  = 3'b111;

  // Map a code to its multiplexer lane; reserved codes map to zero.
  function automatic src_vec_t code_onehot(input src_code_t c);
    src_vec_t v;
    v = '0;
    case (c)
      CODE_XTAL: v[0] = 1'b1;
      CODE_PLL:  v[1] = 1'b1;
      CODE_LRC:  v[2] = 1'b1;
      CODE_HRC:  v[3] = 1'b1;
      default:   v = '0;
    endcase
    return v;
  endfunction

  function automatic logic code_legal(input src_code_t c);
    return |code_onehot(c);
  endfunction

  // Stable flag of the lane a code selects.
  function automatic logic code_ready(input src_code_t c, input src_vec_t stab);
    return |(code_onehot(c) & stab);
  endfunction

  function automatic src_code_t boot_code(input logic hirc);
    return hirc ? CODE_HRC : CODE_XTAL;
  endfunction
endpackage

// File: rtl/clksw_unlock.sv
module clksw_unlock #(
  parameter int KEY_W = 8,
  parameter logic [KEY_W-1:0] KEY_A = 8'h59,
  parameter logic [KEY_W-1:0] KEY_B = 8'h16,
  parameter logic [KEY_W-1:0] KEY_C = 8'h88
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_wr,
  input  logic [KEY_W-1:0] key_data,
  output logic             unlocked
);
  typedef enum logic [1:0] {ST_IDLE, ST_GOT_A, ST_GOT_B, ST_OPEN} stage_t;
  stage_t stage_q, stage_d;

  // A byte that breaks the chain restarts it; the first key byte begins a new one.
  wire stage_t restart_stage = (key_data == KEY_A) ? ST_GOT_A : ST_IDLE;

  always_comb begin
    stage_d = stage_q;
    if (key_wr) begin
      case (stage_q)
        ST_IDLE:  stage_d = restart_stage;
        ST_GOT_A: stage_d = (key_data == KEY_B) ? ST_GOT_B : restart_stage;
        ST_GOT_B: stage_d = (key_data == KEY_C) ? ST_OPEN  : restart_stage;
        default:  stage_d = restart_stage;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= ST_IDLE;
    else        stage_q <= stage_d;
  end

  assign unlocked = (stage_q == ST_OPEN);

  // R7: a protection write while open always closes the lock
  a_r7_relock: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr && unlocked |=> !unlocked);
  // R6: without a protection write the lock state holds
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !key_wr |=> $stable(unlocked));
  // R6: opening needs the final key byte
  a_r6_open_needs_last: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked && !(key_wr && key_data == KEY_C) |=> !unlocked);
endmodule

// File: rtl/clksw_ctrl.sv
module clksw_ctrl
  import clksw_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      boot_hirc,
  input  logic      sel_wr,
  input  src_code_t sel_data,
  input  logic      wr_open,
  input  src_vec_t  src_stable,
  output src_code_t active_code,
  output src_code_t sel_field,
  output logic      switch_fail
);
  src_code_t active_q, field_q;
  logic      fail_q;

  // Named internal events, shared by the logic and its assertions.
  logic wr_accept;     // legal code written while unlocked
  logic tgt_ready_wr;  // target of the accepted write is stable
  logic pend_ready;    // pending target has become stable

  assign wr_accept    = sel_wr && wr_open && code_legal(sel_data);
  assign tgt_ready_wr = code_ready(sel_data, src_stable);
  assign pend_ready   = fail_q && code_ready(field_q, src_stable);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= boot_code(boot_hirc);
      field_q  <= boot_code(boot_hirc);
      fail_q   <= 1'b0;
    end else if (wr_accept) begin
      field_q <= sel_data;
      if (tgt_ready_wr) begin
        active_q <= sel_data;
        fail_q   <= 1'b0;
      end else begin
        fail_q   <= 1'b1;
      end
    end else if (pend_ready) begin
      active_q <= field_q;
      fail_q   <= 1'b0;
    end
  end

  assign active_code = active_q;
  assign sel_field   = field_q;
  assign switch_fail = fail_q;

  // R3: stable target switches at the next edge
  a_r3_switch: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept && tgt_ready_wr |=> (active_code == $past(sel_data)) && !switch_fail);
  // R4: unstable target defers, keeps current source
  a_r4_defer: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept && !tgt_ready_wr |=> switch_fail && $stable(active_code));
  // R4: while pending and target unstable, nothing moves
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    switch_fail && !pend_ready && !wr_accept |=> switch_fail && $stable(active_code));
  // R5: automatic completion once the target is stable
  a_r5_auto: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_accept && pend_ready |=> !switch_fail && (active_code == $past(sel_field)));
  // R8: locked writes are dropped
  a_r8_locked: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr && !wr_open |=> $stable(sel_field));
  // R9: reserved codes are dropped
  a_r9_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr && !code_legal(sel_data) |=> $stable(sel_field));
endmodule

// File: rtl/clksw_decode.sv
module clksw_decode
  import clksw_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  src_code_t active_code,
  output src_vec_t  src_onehot
);
  generate
    for (genvar i = 0; i < SRC_N; i++) begin : g_lane
      assign src_onehot[i] = code_onehot(active_code)[i];
    end
  endgenerate

  // R1: the multiplexer control always names exactly one source
  a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(src_onehot) == 1);
endmodule

// File: rtl/sysclk_src_switch.sv
module sysclk_src_switch
  import clksw_pkg::*;
#(
  parameter int KEY_W = 8,
  parameter logic [KEY_W-1:0] KEY_A = 8'h59,
  parameter logic [KEY_W-1:0] KEY_B = 8'h16,
  parameter logic [KEY_W-1:0] KEY_C = 8'h88
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boot_hirc,
  input  logic             key_wr,
  input  logic [KEY_W-1:0] key_data,
  input  logic             sel_wr,
  input  logic [2:0]       sel_data,
  input  logic [3:0]       src_stable,
  output logic [3:0]       src_onehot,
  output logic [2:0]       active_code,
  output logic [2:0]       sel_field,
  output logic             switch_fail,
  output logic             unlocked
);
  logic open_w;

  clksw_unlock #(.KEY_W(KEY_W), .KEY_A(KEY_A), .KEY_B(KEY_B), .KEY_C(KEY_C)) u_unlock (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_wr   (key_wr),
    .key_data (key_data),
    .unlocked (open_w)
  );

  clksw_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .boot_hirc   (boot_hirc),
    .sel_wr      (sel_wr),
    .sel_data    (sel_data),
    .wr_open     (open_w),
    .src_stable  (src_stable),
    .active_code (active_code),
    .sel_field   (sel_field),
    .switch_fail (switch_fail)
  );

  clksw_decode u_decode (
    .clk         (clk),
    .rst_n       (rst_n),
    .active_code (active_code),
    .src_onehot  (src_onehot)
  );

  assign unlocked = open_w;

  // R7: select writes never disturb the lock
  a_r7_sel_no_lock_change: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr && !key_wr |=> $stable(unlocked));
endmodule

// File: tb/test_sysclk_src_switch.sv
`timescale 1ns/1ps
module test_sysclk_src_switch;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       boot_hirc = 1'b0;
  logic       key_wr = 1'b0;
  logic [7:0] key_data = 8'h00;
  logic       sel_wr = 1'b0;
  logic [2:0] sel_data = 3'b000;
  logic [3:0] src_stable = 4'b1111;
  logic [3:0] src_onehot;
  logic [2:0] active_code, sel_field;
  logic       switch_fail, unlocked;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sysclk_src_switch i_sysclk_src_switch (
    .clk(clk), .rst_n(rst_n), .boot_hirc(boot_hirc),
    .key_wr(key_wr), .key_data(key_data),
    .sel_wr(sel_wr), .sel_data(sel_data), .src_stable(src_stable),
    .src_onehot(src_onehot), .active_code(active_code), .sel_field(sel_field),
    .switch_fail(switch_fail), .unlocked(unlocked)
  );

  // Expected lane from a code, written as an if-chain of its own.
  function automatic logic [3:0] lane_of(input logic [2:0] c);
    if (c == 3'd0) return 4'd1;
    if (c == 3'd2) return 4'd2;
    if (c == 3'd3) return 4'd4;
    if (c == 3'd7) return 4'd8;
    return 4'd0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic key(input logic [7:0] b);
    @(negedge clk); key_wr = 1'b1; key_data = b;
    @(negedge clk); key_wr = 1'b0;
  endtask

  task automatic sel(input logic [2:0] c);
    @(negedge clk); sel_wr = 1'b1; sel_data = c;
    @(negedge clk); sel_wr = 1'b0;
  endtask

  task automatic do_reset(input logic hirc);
    @(negedge clk); boot_hirc = hirc; rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
  endtask

  // {code, stable flags during write, expected active, expected fail}
  localparam int NV = 7;
  localparam logic [10:0] VEC [NV] = '{
    {3'b010, 4'b1111, 3'b010, 1'b0},  // R3 to PLL
    {3'b011, 4'b1111, 3'b011, 1'b0},  // R3 to low RC
    {3'b111, 4'b1111, 3'b111, 1'b0},  // R3 to high RC
    {3'b000, 4'b1110, 3'b111, 1'b1},  // R4 crystal unstable, deferred
    {3'b001, 4'b1110, 3'b111, 1'b1},  // R9 reserved while pending
    {3'b010, 4'b1111, 3'b010, 1'b0},  // R3 stable request supersedes
    {3'b000, 4'b1111, 3'b000, 1'b0}   // R3 back to crystal
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset(1'b0);
    chk("R2 active after reset", active_code, 3'b000);
    chk("R2 field after reset", sel_field, 3'b000);
    chk("R2 fail after reset", switch_fail, 0);
    chk("R2 locked after reset", unlocked, 0);
    chk("R1 onehot crystal", src_onehot, 4'b0001);

    sel(3'b111);
    chk("R8 locked write active", active_code, 3'b000);
    chk("R8 locked write field", sel_field, 3'b000);

    key(8'h59); key(8'h16);
    chk("R6 partial sequence locked", unlocked, 0);
    key(8'h88);
    chk("R6 unlocked after three keys", unlocked, 1);

    for (int i = 0; i < NV; i++) begin
      logic [2:0] c, ea; logic [3:0] st; logic ef;
      {c, st, ea, ef} = VEC[i];
      @(negedge clk); src_stable = st;
      sel(c);
      chk("R3/R4 table active", active_code, ea);
      chk("R4/R5 table fail", switch_fail, ef);
      chk("R1 table onehot", src_onehot, lane_of(ea));
      if (c == 3'b001) chk("R9 reserved field kept", sel_field, 3'b000);
    end

    @(negedge clk); src_stable = 4'b1011;
    sel(3'b011);
    chk("R4 deferred fail", switch_fail, 1);
    chk("R4 deferred field", sel_field, 3'b011);
    repeat (4) @(negedge clk);
    chk("R4 held on old source", active_code, 3'b000);
    src_stable = 4'b1111;
    @(negedge clk);
    chk("R5 auto switch active", active_code, 3'b011);
    chk("R5 auto switch fail clear", switch_fail, 0);
    chk("R1 onehot low RC", src_onehot, 4'b0100);
    chk("R7 select writes keep unlock", unlocked, 1);

    key(8'h00);
    chk("R7 stray byte relocks", unlocked, 0);
    sel(3'b111);
    chk("R8 locked write ignored", active_code, 3'b011);

    key(8'h59); key(8'h16); key(8'h00);
    chk("R7 broken sequence locked", unlocked, 0);
    key(8'h59); key(8'h59); key(8'h16); key(8'h88);
    chk("R7 restart on first key", unlocked, 1);
    sel(3'b111);
    chk("R3 switch after restart", active_code, 3'b111);

    do_reset(1'b1);
    chk("R2 boot high RC active", active_code, 3'b111);
    chk("R2 boot high RC field", sel_field, 3'b111);
    chk("R2 boot relocked", unlocked, 0);
    chk("R1 onehot high RC", src_onehot, 4'b1000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule